// File: doc/BRIEF.md
# Paged Program Counter Unit

This block produces the instruction fetch address for a small two-cycle microcontroller core whose 12-bit instruction words fill a 4096-word program store. It holds the 12-bit program counter and a shallow return-address stack. Each fetch slot selects the next address in one of several ways. It can step by one or by two (skip). It can load a jump target built from a 9-bit instruction field. It can load a subroutine target built from an 8-bit field. It can pop a return address. It can take a data-bus write into the readable low byte of the counter.

The program space is divided into eight pages of 512 words. The upper three address bits of jump, call and low-byte-write targets come from page-select bits held in the status register. A subroutine target always has bit 8 cleared, so subroutine entry points lie in the lower half of a page. The low byte of the counter is also presented as a readable data value, so software can build computed jumps.

The core strobes `fetchEn` once every two clocks. The counter and the stack change only on those strobes.

Top module: `paged_fetch_counter`

## Requirements
- R1: While `rst` is high and after it is released, `fetchAddr` is 0xFFF. Every return-stack entry resets to 0x000, so a return issued before any call loads 0x000.
- R2: The counter and the stack change only in a cycle where `fetchEn` is high. Request inputs presented without `fetchEn` have no effect. `fetchEn` is never high in two consecutive cycles.
- R3: A fetch strobe with no request loads the counter plus one, modulo 4096. 0xFFF therefore wraps to 0x000.
- R4: A fetch strobe with `skipReq` loads the counter plus two, modulo 4096.
- R5: A fetch strobe with `gotoReq` loads `{pageSel[2:0], instField[8:0]}`.
- R6: A fetch strobe with `callReq` loads `{pageSel[2:0], 1'b0, instField[7:0]}` and pushes the old counter plus one onto the stack top.
- R7: A fetch strobe with `retReq` loads the stack top. The deeper entry moves up, and the bottom entry keeps its value.
- R8: The stack holds two entries. A push onto a full stack silently drops the oldest entry.
- R9: A fetch strobe with `pclWrite` loads `{pageSel[2:0], 1'b0, dataIn[7:0]}`.
- R10: `pclOut` always equals bits 7:0 of `fetchAddr`.
- R11: When several requests share one strobe, only one takes effect. The priority is goto, then call, then return, then low-byte write, then skip. A request that loses does not touch the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchEn | input | 1 | Fetch-slot strobe, high one cycle in two |
| skipReq | input | 1 | Advance by two |
| gotoReq | input | 1 | Direct jump within the selected page |
| callReq | input | 1 | Subroutine call with return push |
| retReq | input | 1 | Return, pop the stack top |
| pclWrite | input | 1 | Data write to the counter low byte |
| instField | input | 9 | Address field of the instruction |
| pageSel | input | 3 | Page-select bits from the status register |
| dataIn | input | 8 | Data bus for low-byte writes |
| fetchAddr | output | 12 | Program counter, used as the fetch address |
| pclOut | output | 8 | Readable low byte of the counter |

## Verification
The bench builds the block with its default parameters: a 3-bit page select, a 9-bit jump field, an 8-bit call field and a two-entry stack. With those values the top page (7) can be reached, and the wrap from 0xFFF to 0x000 is exercised by both a step and a skip. Three nested calls are enough to force the stack to drop its oldest entry, and three returns in a row expose the bottom entry being kept. Jump fields with bit 8 set are fed to calls to confirm that the bit is cleared, and mixed request patterns probe the priority order.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef struct packed {
    logic load;
    logic doGoto;
    logic doCall;
    logic doRet;
    logic doPcl;
    logic doSkip;
  } pfcStrobes_t;
endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fetchEn,
  input  logic        skipReq,
  input  logic        gotoReq,
  input  logic        callReq,
  input  logic        retReq,
  input  logic        pclWrite,
  output pfcStrobes_t strb
);
  always_comb begin
    strb = '0;
    strb.load = fetchEn;
    if (fetchEn) begin
      if (gotoReq)       strb.doGoto = 1'b1;
      else if (callReq)  strb.doCall = 1'b1;
      else if (retReq)   strb.doRet  = 1'b1;
      else if (pclWrite) strb.doPcl  = 1'b1;
      else if (skipReq)  strb.doSkip = 1'b1;
    end
  end

  // R11: at most one action per slot
  assert_single_action_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.doGoto, strb.doCall, strb.doRet, strb.doPcl, strb.doSkip}));

  // R2: fetch slots are spaced two clocks apart
  assert_slot_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    fetchEn |=> !fetchEn);

  // R11: goto wins over a simultaneous call
  assert_goto_priority_R11: assert property (@(posedge clk) disable iff (rst)
    (fetchEn && gotoReq) |-> !strb.doCall);
endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int PAGE_W      = 3,
  parameter int JUMP_W      = 9,
  parameter int CALL_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pfcStrobes_t                   strb,
  input  logic [JUMP_W-1:0]             instField,
  input  logic [PAGE_W-1:0]             pageSel,
  input  logic [DATA_W-1:0]             dataIn,
  output logic [PAGE_W+JUMP_W-1:0]      pcValue
);
  localparam int ADDR_W   = PAGE_W + JUMP_W;
  localparam int CALL_GAP = JUMP_W - CALL_W;
  localparam int DATA_GAP = JUMP_W - DATA_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcNext;
  logic [ADDR_W-1:0] pcInc;
  logic [ADDR_W-1:0] retStack [STACK_DEPTH];

  assign pcInc = pcReg + ADDR_W'(1);

  always_comb begin
    pcNext = pcInc;
    if (strb.doGoto)      pcNext = {pageSel, instField};
    else if (strb.doCall) pcNext = {pageSel, {CALL_GAP{1'b0}}, instField[CALL_W-1:0]};
    else if (strb.doRet)  pcNext = retStack[0];
    else if (strb.doPcl)  pcNext = {pageSel, {DATA_GAP{1'b0}}, dataIn};
    else if (strb.doSkip) pcNext = pcReg + ADDR_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst)            pcReg <= '1;
    else if (strb.load) pcReg <= pcNext;
  end

  genvar gi;
  generate
    for (gi = 0; gi < STACK_DEPTH; gi++) begin : g_stack
      logic [ADDR_W-1:0] pushVal;
      logic [ADDR_W-1:0] popVal;
      if (gi == 0) begin : g_top
        assign pushVal = pcInc;
      end else begin : g_below
        assign pushVal = retStack[gi-1];
      end
      if (gi == STACK_DEPTH - 1) begin : g_bottom
        assign popVal = retStack[gi];
      end else begin : g_upper
        assign popVal = retStack[gi+1];
      end
      always_ff @(posedge clk) begin
        if (rst)              retStack[gi] <= '0;
        else if (strb.doCall) retStack[gi] <= pushVal;
        else if (strb.doRet)  retStack[gi] <= popVal;
      end
    end
  endgenerate

  assign pcValue = pcReg;

  // R2: no slot, no change
  assert_hold_between_slots_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(pcValue));

  // R5: jump target from page bits and field
  assert_goto_target_R5: assert property (@(posedge clk) disable iff (rst)
    strb.doGoto |=> pcValue == {$past(pageSel), $past(instField)});

  // R6: call target has bit 8 cleared and the page on top
  assert_call_bit8_R6: assert property (@(posedge clk) disable iff (rst)
    strb.doCall |=> (pcValue[CALL_W] == 1'b0 && pcValue[ADDR_W-1 -: PAGE_W] == $past(pageSel)));

  // R9: low-byte write
  assert_pcl_write_R9: assert property (@(posedge clk) disable iff (rst)
    strb.doPcl |=> (pcValue[DATA_W-1:0] == $past(dataIn) && pcValue[DATA_W] == 1'b0));

  // R6: pushed return is the address after the call
  assert_push_value_R6: assert property (@(posedge clk) disable iff (rst)
    strb.doCall |=> retStack[0] == $past(pcValue) + ADDR_W'(1));
endmodule

// File: rtl/paged_fetch_counter.sv
module paged_fetch_counter
  import pfc_pkg::*;
#(
  parameter int PAGE_W      = 3,
  parameter int JUMP_W      = 9,
  parameter int CALL_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetchEn,
  input  logic                     skipReq,
  input  logic                     gotoReq,
  input  logic                     callReq,
  input  logic                     retReq,
  input  logic                     pclWrite,
  input  logic [JUMP_W-1:0]        instField,
  input  logic [PAGE_W-1:0]        pageSel,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [PAGE_W+JUMP_W-1:0] fetchAddr,
  output logic [DATA_W-1:0]        pclOut
);
  pfcStrobes_t strb;

  pfc_ctrl i_ctrl (
    .clk(clk), .rst(rst), .fetchEn(fetchEn), .skipReq(skipReq),
    .gotoReq(gotoReq), .callReq(callReq), .retReq(retReq),
    .pclWrite(pclWrite), .strb(strb)
  );

  pfc_datapath #(
    .PAGE_W(PAGE_W), .JUMP_W(JUMP_W), .CALL_W(CALL_W),
    .DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)
  ) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .instField(instField),
    .pageSel(pageSel), .dataIn(dataIn), .pcValue(fetchAddr)
  );

  assign pclOut = fetchAddr[DATA_W-1:0];

  // R10: readable low byte tracks the counter
  assert_low_byte_R10: assert property (@(posedge clk) disable iff (rst)
    pclOut == fetchAddr[7:0]);
endmodule

// File: tb/test_paged_fetch_counter.sv
module test_paged_fetch_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchEn = 0, skipReq = 0, gotoReq = 0, callReq = 0, retReq = 0, pclWrite = 0;
  logic [8:0]  instField = '0;
  logic [2:0]  pageSel = '0;
  logic [7:0]  dataIn = '0;
  logic [11:0] fetchAddr;
  logic [7:0]  pclOut;

  always #4 clk = ~clk;

  paged_fetch_counter i_paged_fetch_counter (
    .clk(clk), .rst(rst), .fetchEn(fetchEn), .skipReq(skipReq),
    .gotoReq(gotoReq), .callReq(callReq), .retReq(retReq), .pclWrite(pclWrite),
    .instField(instField), .pageSel(pageSel), .dataIn(dataIn),
    .fetchAddr(fetchAddr), .pclOut(pclOut)
  );

  typedef struct { logic [11:0] addr; string tag; } expItem_t;
  expItem_t expQ[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [11:0] mPc;
  logic [11:0] mStk [2];

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per cycle, compared just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(fetchAddr, it.addr, it.tag);
        check({4'h0, pclOut}, {4'h0, it.addr[7:0]}, {it.tag, " low byte R10"});
      end
    end
  end

  // driver: one fetch slot, then one idle cycle with junk requests
  task automatic slot(input bit g, input bit c, input bit r, input bit p, input bit s,
                      input logic [8:0] fld, input logic [2:0] pg, input logic [7:0] d,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    fetchEn = 1; gotoReq = g; callReq = c; retReq = r; pclWrite = p; skipReq = s;
    instField = fld; pageSel = pg; dataIn = d;
    if (g)      mPc = {pg, fld};
    else if (c) begin mStk[1] = mStk[0]; mStk[0] = mPc + 12'd1; mPc = {pg, 1'b0, fld[7:0]}; end
    else if (r) begin mPc = mStk[0]; mStk[0] = mStk[1]; end
    else if (p) mPc = {pg, 1'b0, d};
    else if (s) mPc = mPc + 12'd2;
    else        mPc = mPc + 12'd1;
    it.addr = mPc; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    fetchEn = 0; gotoReq = 1; callReq = 1; retReq = 1; pclWrite = 1; skipReq = 1;
    instField = 9'h155; pageSel = 3'd3; dataIn = 8'hA5;
    it.tag = "R2 idle cycle ignores requests";
    expQ.push_back(it);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mPc = 12'hFFF; mStk[0] = '0; mStk[1] = '0;
    repeat (3) @(negedge clk);
    check(fetchAddr, 12'hFFF, "R1 reset value in reset");
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(fetchAddr, 12'hFFF, "R1 value after reset");
    check({4'h0, pclOut}, 12'h0FF, "R1 R10 low byte after reset");

    slot(0,0,0,0,0, 9'h000, 3'd0, 8'h00, "R3 wrap FFF to 000");
    slot(0,0,0,0,0, 9'h000, 3'd0, 8'h00, "R3 step");
    slot(0,0,0,0,1, 9'h000, 3'd0, 8'h00, "R4 skip");
    slot(0,0,1,0,0, 9'h000, 3'd0, 8'h00, "R1 return from reset stack");
    slot(1,0,0,0,0, 9'h1A3, 3'd5, 8'h00, "R5 goto page 5");
    slot(0,1,0,0,0, 9'h1FF, 3'd2, 8'h00, "R6 call clears bit 8");
    slot(0,1,0,0,0, 9'h034, 3'd7, 8'h00, "R6 nested call page 7");
    slot(0,1,0,0,0, 9'h110, 3'd0, 8'h00, "R8 call on full stack");
    slot(0,0,1,0,0, 9'h000, 3'd0, 8'h00, "R7 return top");
    slot(0,0,1,0,0, 9'h000, 3'd0, 8'h00, "R8 oldest dropped");
    slot(0,0,1,0,0, 9'h000, 3'd0, 8'h00, "R7 bottom entry kept");
    slot(0,0,0,1,0, 9'h000, 3'd6, 8'h7C, "R9 low byte write");
    slot(1,0,0,0,0, 9'h1FE, 3'd7, 8'h00, "R5 goto top page");
    slot(0,0,0,0,1, 9'h000, 3'd0, 8'h00, "R4 skip wraps");
    slot(1,1,0,0,0, 9'h0C0, 3'd1, 8'h00, "R11 goto beats call");
    slot(0,0,1,0,0, 9'h000, 3'd0, 8'h00, "R11 losing call did not push");
    slot(0,1,1,1,1, 9'h022, 3'd4, 8'h99, "R11 call beats return");
    slot(0,0,1,1,1, 9'h000, 3'd2, 8'h44, "R11 return beats write");
    slot(0,0,0,1,1, 9'h000, 3'd3, 8'hE1, "R11 write beats skip");
    @(negedge clk);
    fetchEn = 0; gotoReq = 0; callReq = 0; retReq = 0; pclWrite = 0; skipReq = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule